// File: doc/BRIEF.md
# Chunked Hamming Parity Generator

This block computes single-error-correcting Hamming parity over a stream of bytes, one fixed-size chunk at a time (256 bytes by default). Each accepted byte adds to two accumulators. Column parity covers the bit positions inside a byte. Line parity covers the position of the byte within its chunk. When the last byte of a chunk is accepted, the block latches a raw parity word, pulses a done strobe and restarts the accumulators, so each chunk is covered on its own.

The raw word is also turned into the code that is kept in a flash spare area. That code is the raw word shifted up by two places and then inverted. It is offered two ways: as a parallel word, and as a short byte sequence that starts with the most significant byte, ready to be appended after the page data. A clear input abandons the chunk in progress before a new page transfer begins. An enable input gates accumulation as a whole.

Top module: `hpg_chunk_parity`

## Requirements
- R1: After reset, `raw_o` is 0, `code_o` is 24'hFFFFFF, and `done_o` and `code_byte_vld_o` are low.
- R2: Column parity sits in `raw_o[5:0]`. For j in 0..2, bit 2j is the XOR of every data bit, across the chunk, whose bit position (0..7) has bit j clear. Bit 2j+1 is the same XOR over positions that have bit j set.
- R3: Line parity sits in `raw_o[20:6]`. Take p as the XOR of the 8 bits of one byte and idx as that byte's offset (0..255) in the chunk. For k in 0..6, bit 6+2k is the XOR of p over bytes whose idx has bit k clear, and bit 7+2k is the XOR of p over bytes whose idx has bit k set. Bit 20 is the XOR of p over bytes whose idx has bit 7 set.
- R4: A byte is accepted when `vld_i` and `en_i` are high and `clr_i` is low. When the 256th accepted byte of a chunk is taken, `done_o` is high for exactly the following cycle and `raw_o` holds that chunk's parity. Accumulation then restarts from zero, so chunks do not influence one another. Idle cycles inside a chunk do not matter.
- R5: `raw_o` changes only in a cycle in which `done_o` is high, and it otherwise keeps the last chunk's value.
- R6: `code_o` equals the bitwise inverse of `{3'b000, raw_o, 2'b00}`, so bit 23 and bits [1:0] of `code_o` are always 1.
- R7: Starting in the cycle in which `done_o` is high, `code_byte_vld_o` is high for three consecutive cycles. Over those cycles `code_byte_o` carries the code bytes [23:16], [15:8] and [7:0], in that order.
- R8: A byte presented with `en_i` low is ignored. It neither advances the byte offset nor changes the parity.
- R9: `clr_i` clears both accumulators and the byte offset. Any byte presented in the same cycle is discarded, and no done strobe follows it even if that byte would have completed the chunk. A byte sequence in progress stops in the next cycle. `raw_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Abandon the current chunk and restart accumulation |
| en_i | input | 1 | Accumulation enable |
| vld_i | input | 1 | Data byte valid |
| data_i | input | 8 | Data byte |
| raw_o | output | 21 | Latched parity word: line parity [20:6], column parity [5:0] |
| code_o | output | 24 | Stored-form code derived from `raw_o` |
| done_o | output | 1 | One-cycle strobe after a chunk completes |
| code_byte_o | output | 8 | Serial code byte, most significant first |
| code_byte_vld_o | output | 1 | `code_byte_o` is valid |

## Verification
Two functions can land in the same cycle. Clear can coincide with the byte that would complete a chunk, and clear can also coincide with the first cycle of the code byte sequence. The first case is provoked by presenting the 256th byte with `clr_i` high. The bench then checks that no done strobe follows, and that the next full chunk produces parity computed from that chunk alone. The second case is provoked by raising `clr_i` in the done cycle. The bench then checks that the sequence is cut off in the next cycle while `raw_o` keeps the completed chunk's parity. The parity fields themselves are swept with single set bits across every bit position and every offset bit, and also with dense and pseudo-random chunks.

// File: rtl/hpg_pkg.sv
package hpg_pkg;

    localparam int BYTE_W = 8;
    localparam int COL_W  = 6;

    // One beat of the input stream after qualification
    typedef struct packed {
        logic              take;
        logic [BYTE_W-1:0] data;
    } hpg_beat_t;

    // Column-parity contribution of one byte: pair j splits bit positions by bit j
    function automatic logic [COL_W-1:0] col_contrib(input logic [BYTE_W-1:0] b);
        logic [COL_W-1:0] r;
        r = '0;
        for (int p = 0; p < BYTE_W; p++) begin
            for (int j = 0; j < 3; j++) begin
                if (b[p]) begin
                    if (p[j]) r[2*j+1] = ~r[2*j+1];
                    else      r[2*j]   = ~r[2*j];
                end
            end
        end
        return r;
    endfunction

    // Stored form: raw shifted up two places, inverted, cut to the code width
    function automatic logic [23:0] stored_form(input logic [23:0] raw_ext);
        return ~(raw_ext << 2);
    endfunction

endpackage

// File: rtl/hpg_col_acc.sv
module hpg_col_acc
    import hpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  hpg_beat_t        beat,
    output logic [COL_W-1:0] col_nxt
);
    logic [COL_W-1:0] acc_q;

    always_comb begin
        col_nxt = acc_q;
        if (beat.take) col_nxt = acc_q ^ col_contrib(beat.data);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) acc_q <= '0;
        else                acc_q <= col_nxt;
    end
endmodule

// File: rtl/hpg_line_acc.sv
module hpg_line_acc
    import hpg_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int LINE_W = 2*IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  hpg_beat_t         beat,
    input  logic [IDX_W-1:0]  idx,
    output logic [LINE_W-1:0] line_nxt
);
    logic bpar;
    assign bpar = beat.take & (^beat.data);

    for (genvar k = 0; k < IDX_W; k++) begin : g_bit
        logic odd_q, odd_n;
        assign odd_n = odd_q ^ (bpar & idx[k]);
        always_ff @(posedge clk) begin
            if (rst || restart) odd_q <= 1'b0;
            else                odd_q <= odd_n;
        end
        if (k < IDX_W-1) begin : g_even
            // even half of the top offset bit is derivable, so it is not kept
            logic even_q, even_n;
            assign even_n = even_q ^ (bpar & ~idx[k]);
            always_ff @(posedge clk) begin
                if (rst || restart) even_q <= 1'b0;
                else                even_q <= even_n;
            end
            assign line_nxt[2*k]   = even_n;
            assign line_nxt[2*k+1] = odd_n;
        end else begin : g_top
            assign line_nxt[2*k] = odd_n;
        end
    end
endmodule

// File: rtl/hpg_code_ser.sv
module hpg_code_ser #(
    parameter int NBYTES = 3,
    localparam int CW    = NBYTES*8,
    localparam int CNT_W = $clog2(NBYTES+1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] code_i,
    output logic [7:0]    byte_o,
    output logic          vld_o
);
    logic [CW-1:0]    shf_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            shf_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(NBYTES);
            shf_q <= code_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            shf_q <= shf_q << 8;
        end
    end

    assign byte_o = shf_q[CW-1 -: 8];
    assign vld_o  = (cnt_q != '0);

    // R7
    ser_first_byte_chk: assert property (@(posedge clk) disable iff (rst)
        load && !clr |=> vld_o && byte_o == $past(code_i[CW-1 -: 8]));
    // R9
    ser_clear_stop_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !vld_o);
endmodule

// File: rtl/hpg_chunk_parity.sv
module hpg_chunk_parity
    import hpg_pkg::*;
#(
    parameter int CHUNK_BYTES = 256,
    localparam int IDX_W      = $clog2(CHUNK_BYTES),
    localparam int LINE_W     = 2*IDX_W - 1,
    localparam int RAW_W      = COL_W + LINE_W,
    localparam int CODE_BYTES = (RAW_W + 2 + 7) / 8,
    localparam int CODE_W     = CODE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              vld_i,
    input  logic [7:0]        data_i,
    output logic [RAW_W-1:0]  raw_o,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o,
    output logic [7:0]        code_byte_o,
    output logic              code_byte_vld_o
);
    hpg_beat_t         beat;
    logic [IDX_W-1:0]  idx_q;
    logic              last_beat, restart;
    logic [COL_W-1:0]  col_nxt;
    logic [LINE_W-1:0] line_nxt;
    logic [RAW_W-1:0]  raw_nxt, raw_q;
    logic              done_q;

    assign beat.take = vld_i & en_i & ~clr_i;
    assign beat.data = data_i;
    assign last_beat = beat.take && (idx_q == IDX_W'(CHUNK_BYTES-1));
    assign restart   = clr_i | last_beat;

    always_ff @(posedge clk) begin
        if (rst || clr_i)   idx_q <= '0;
        else if (beat.take) idx_q <= idx_q + 1'b1;
    end

    hpg_col_acc u_col (
        .clk(clk), .rst(rst), .restart(restart), .beat(beat), .col_nxt(col_nxt)
    );

    hpg_line_acc #(.IDX_W(IDX_W)) u_line (
        .clk(clk), .rst(rst), .restart(restart), .beat(beat), .idx(idx_q),
        .line_nxt(line_nxt)
    );

    assign raw_nxt = {line_nxt, col_nxt};

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_beat;
            if (last_beat) raw_q <= raw_nxt;
        end
    end

    assign raw_o  = raw_q;
    assign done_o = done_q;
    assign code_o = CODE_W'(stored_form(24'(raw_q)));

    hpg_code_ser #(.NBYTES(CODE_BYTES)) u_ser (
        .clk(clk), .rst(rst), .clr(clr_i), .load(last_beat),
        .code_i(CODE_W'(stored_form(24'(raw_nxt)))),
        .byte_o(code_byte_o), .vld_o(code_byte_vld_o)
    );

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R5
    raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(raw_o) |-> done_o);
    // R8
    idle_no_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i && !(vld_i && en_i) |=> $stable(idx_q));
    // R9
    clear_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !done_o && !code_byte_vld_o);
endmodule

// File: tb/hpg_chunk_parity_tb_top.sv
module hpg_chunk_parity_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0, en_i = 1'b0, vld_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic [20:0] raw_o;
    logic [23:0] code_o;
    logic        done_o;
    logic [7:0]  code_byte_o;
    logic        code_byte_vld_o;

    int errors = 0;
    int checks = 0;

    logic [5:0] m_col;
    logic [7:0] m_odd, m_even;
    int         m_cnt;
    logic [20:0] last_raw;

    always #5 clk = ~clk;

    hpg_chunk_parity dut_i (
        .clk(clk), .rst(rst), .clr_i(clr_i), .en_i(en_i), .vld_i(vld_i),
        .data_i(data_i), .raw_o(raw_o), .code_o(code_o), .done_o(done_o),
        .code_byte_o(code_byte_o), .code_byte_vld_o(code_byte_vld_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] model_raw();
        logic [14:0] ln;
        for (int k = 0; k < 7; k++) begin
            ln[2*k]   = m_even[k];
            ln[2*k+1] = m_odd[k];
        end
        ln[14] = m_odd[7];
        return {ln, m_col};
    endfunction

    function automatic logic [23:0] exp_code(input logic [20:0] r);
        logic [23:0] v;
        v = {3'b000, r} * 24'd4;
        return v ^ 24'hFFFFFF;
    endfunction

    task automatic model_reset();
        m_col = '0; m_odd = '0; m_even = '0; m_cnt = 0;
    endtask

    task automatic model_add(input logic [7:0] b);
        logic p;
        p = ^b;
        for (int pos = 0; pos < 8; pos++)
            if (b[pos])
                for (int j = 0; j < 3; j++)
                    if ((pos >> j) & 1) m_col[2*j+1] ^= 1'b1;
                    else                m_col[2*j]   ^= 1'b1;
        for (int k = 0; k < 8; k++)
            if (p) begin
                if ((m_cnt >> k) & 1) m_odd[k]  ^= 1'b1;
                else                  m_even[k] ^= 1'b1;
            end
        m_cnt++;
    endtask

    function automatic logic [7:0] pat(input int mode, input int i, input int a,
                                       input int b);
        case (mode)
            0: return 8'h00;
            1: return 8'hFF;
            2: return (i == a) ? 8'(1 << b) : 8'h00;
            3: return 8'(i*a + b) ^ 8'(i >> 2);
            default: return 8'(i);
        endcase
    endfunction

    task automatic drive(input logic v, input logic e, input logic c,
                         input logic [7:0] d);
        @(negedge clk);
        vld_i = v; en_i = e; clr_i = c; data_i = d;
    endtask

    // feed a chunk; gaps inserts idle and disabled junk beats (R8)
    task automatic feed(input int mode, input int a, input int b, input bit gaps,
                        input int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] d;
            if (gaps && (i % 9 == 4)) begin
                drive(1'b0, 1'b1, 1'b0, 8'hA5);
                drive(1'b1, 1'b0, 1'b0, 8'h5A); // R8 ignored byte
            end
            if (i == 128) begin
                #1;
                chk(raw_o == last_raw && !done_o, "R5 raw held mid-chunk",
                    32'(raw_o), 32'(last_raw));
            end
            d = pat(mode, i, a, b);
            drive(1'b1, 1'b1, 1'b0, d);
            model_add(d);
        end
    endtask

    task automatic check_done(input string tag, input bit clr_now);
        logic [20:0] er;
        logic [23:0] ec;
        er = model_raw();
        ec = exp_code(er);
        drive(1'b0, 1'b1, clr_now, 8'h00);
        #1;
        chk(done_o === 1'b1, {tag, " R4 done"}, 32'(done_o), 1);
        chk(raw_o === er, {tag, " R2 R3 raw"}, 32'(raw_o), 32'(er));
        chk(code_o === ec, {tag, " R6 code"}, code_o, ec);
        chk(code_byte_vld_o && code_byte_o === ec[23:16], {tag, " R7 byte0"},
            32'(code_byte_o), 32'(ec[23:16]));
        last_raw = er;
        model_reset();
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        #1;
        chk(done_o === 1'b0, {tag, " R4 single"}, 32'(done_o), 0);
        if (clr_now) begin
            chk(code_byte_vld_o === 1'b0, {tag, " R9 seq stop"},
                32'(code_byte_vld_o), 0);
            chk(raw_o === er, {tag, " R9 raw kept"}, 32'(raw_o), 32'(er));
            drive(1'b0, 1'b1, 1'b0, 8'h00);
            drive(1'b0, 1'b1, 1'b0, 8'h00);
        end else begin
            chk(code_byte_vld_o && code_byte_o === ec[15:8], {tag, " R7 byte1"},
                32'(code_byte_o), 32'(ec[15:8]));
            drive(1'b0, 1'b1, 1'b0, 8'h00);
            #1;
            chk(code_byte_vld_o && code_byte_o === ec[7:0], {tag, " R7 byte2"},
                32'(code_byte_o), 32'(ec[7:0]));
            drive(1'b0, 1'b1, 1'b0, 8'h00);
            #1;
            chk(code_byte_vld_o === 1'b0, {tag, " R7 end"}, 32'(code_byte_vld_o), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        last_raw = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk(raw_o === 21'd0, "R1 raw reset", 32'(raw_o), 0);
        chk(code_o === 24'hFFFFFF, "R1 code reset", code_o, 32'hFFFFFF);
        chk(!done_o && !code_byte_vld_o, "R1 strobes low",
            {30'd0, done_o, code_byte_vld_o}, 0);

        feed(0, 0, 0, 1'b0, 256); check_done("zeros", 1'b0);
        feed(1, 0, 0, 1'b0, 256); check_done("ones", 1'b0);
        feed(4, 0, 0, 1'b1, 256); check_done("index gaps", 1'b0);
        feed(3, 37, 11, 1'b0, 256); check_done("pseudo A", 1'b0);
        feed(3, 91, 200, 1'b1, 256); check_done("pseudo B gaps", 1'b0);

        // single-bit sweep over every bit position and every offset bit (R2 R3)
        for (int bpos = 0; bpos < 8; bpos++) begin
            feed(2, 0, bpos, 1'b0, 256); check_done("single idx0", 1'b0);
            for (int k = 0; k < 8; k++) begin
                feed(2, 1 << k, bpos, 1'b0, 256);
                check_done("single bit", 1'b0);
            end
        end
        feed(2, 255, 7, 1'b0, 256); check_done("single last", 1'b0);

        // R9: clear coincides with the byte that would complete the chunk
        feed(3, 13, 5, 1'b0, 255);
        drive(1'b1, 1'b1, 1'b1, 8'hC3);
        model_reset();
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        #1;
        chk(done_o === 1'b0, "R9 no done on cleared last byte", 32'(done_o), 0);
        chk(raw_o === last_raw, "R9 raw kept after clear", 32'(raw_o), 32'(last_raw));
        feed(3, 59, 77, 1'b0, 256); check_done("after clear", 1'b0);

        // R9: clear during the code byte sequence
        feed(1, 0, 0, 1'b0, 256); check_done("clear in seq", 1'b1);
        feed(4, 0, 0, 1'b0, 256); check_done("after seq clear", 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule